// File: doc/BRIEF.md
# Embedded Core Test Collar

This block wraps an embedded core so that it can be tested in place. Each of the core's input terminals and each of its output terminals passes through a collar cell. Every cell holds a capture/shift flop and a separate hold register. All cells are linked into one serial chain, and a 2-bit mode register is loaded over the same serial port. In functional operation the collar is transparent. In interconnect test, the host-side wiring is observed at the core's inputs and driven at the core's outputs. In core test, the core's inputs are driven from the collar and its responses are captured.

The serial port behaves like a TAP data path. It has a test clock, an active-low asynchronous reset, serial data in and out, and a select line that picks the mode register or the cell chain. Three strobes drive shift, capture and update. A TAP controller outside the block drives the strobes. At most one strobe is meant to be active in a cycle. If several are active, shift wins over capture, and capture wins over update.

Top module: `core_collar`

## Requirements
- R1: While `trstN` is low, the active mode becomes functional, and every cell's hold register and every shift flop clears to 0. As a result, entering interconnect test without a chain update drives all `hostOut` bits to 0.
- R2: In functional mode (code 2'b00, and also the unused code 2'b11), `coreIn` equals `hostIn` and `hostOut` equals `coreOut`, combinationally.
- R3: The mode register is shifted with `selInstr` and `shiftEn` high. `tdi` enters the most significant bit and the bits move toward bit 0, so bit 0 of the code is sent first. The shifted code takes effect only on a clock edge where `selInstr` and `updateEn` are high. Code 2'b01 is interconnect test and 2'b10 is core test.
- R4: When `selInstr` is high, `tdo` shows bit 0 of the mode shift register. Otherwise it shows the last flop of the cell chain.
- R5: The chain has NUM_IN+NUM_OUT cells. `tdi` enters input cell 0, then passes through input cells 1..NUM_IN-1, then output cells 0..NUM_OUT-1. The last output cell drives `tdo`. A bit shifted in first is the first one seen again after a full chain length of shifts.
- R6: In interconnect test, a capture strobe loads each input cell's shift flop with its `hostIn` bit.
- R7: In interconnect test, `hostOut` is driven from the output cells' hold registers.
- R8: In core test, `coreIn` is driven from the input cells' hold registers.
- R9: In core test, a capture strobe loads each output cell's shift flop with its `coreOut` bit.
- R10: A cell whose kind does not capture in the active mode keeps its shifted value on a capture strobe. This covers input cells in core test, output cells in interconnect test, and every cell in functional mode.
- R11: Hold registers change only on a chain update edge (`updateEn` high, `selInstr` low), so `coreIn` and `hostOut` stay steady while the chain shifts or captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial data into the mode register and the cell chain |
| tdo | output | 1 | Serial data out of the selected register |
| selInstr | input | 1 | 1 selects the mode register, 0 selects the cell chain |
| shiftEn | input | 1 | Shift strobe |
| captureEn | input | 1 | Capture strobe |
| updateEn | input | 1 | Update strobe |
| hostIn | input | NUM_IN | Functional signals from the host toward the core |
| coreIn | output | NUM_IN | Signals applied to the core's input terminals |
| coreOut | input | NUM_OUT | The core's output terminals |
| hostOut | output | NUM_OUT | Signals returned to the host |

## Verification
The bench checks that a code shifted into the mode register changes nothing until its update edge. A design that applied the code at shift time would let a half-loaded code steer the core's pins.

It exercises the unused code 2'b11 and expects full transparency. A decoder that matched only one bit would instead drive the pins from the hold registers.

For every mode, it shifts a known pattern through the chain, captures, and shifts the result out. This catches a reversed chain order, a cell capturing in the wrong mode, and a cell that loses its value on a capture strobe.

While shifting, it checks that `coreIn` and `hostOut` do not move. A design whose held values tracked the shift flops would toggle the core's pins on every clock.

// File: rtl/collar_pkg.sv
package collar_pkg;

  localparam int IR_W = 2;

  localparam logic [IR_W-1:0] CODE_FUNCTIONAL = 2'b00;
  localparam logic [IR_W-1:0] CODE_INTERCONN  = 2'b01;
  localparam logic [IR_W-1:0] CODE_CORETEST   = 2'b10;

  // strobes handed from control to the cell datapath
  typedef struct packed {
    logic chainShift;
    logic chainCapture;
    logic chainUpdate;
    logic extTest;
    logic intTest;
  } collarStrobes_t;

endpackage

// File: rtl/collar_cell.sv
module collar_cell (
  input  logic tck,
  input  logic trstN,
  input  logic serialIn,
  input  logic parallelIn,
  input  logic captureSel,
  input  logic shiftSel,
  input  logic updateSel,
  output logic serialOut,
  output logic heldVal
);

  logic shiftFlop;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftFlop <= 1'b0;
    end else if (shiftSel) begin
      shiftFlop <= serialIn;
    end else if (captureSel) begin
      shiftFlop <= parallelIn;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      heldVal <= 1'b0;
    end else if (updateSel) begin
      heldVal <= shiftFlop;
    end
  end

  assign serialOut = shiftFlop;

endmodule

// File: rtl/collar_ctrl.sv
module collar_ctrl
  import collar_pkg::*;
(
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  logic            selInstr,
  input  logic            shiftEn,
  input  logic            captureEn,
  input  logic            updateEn,
  output collarStrobes_t  stb,
  output logic            irSerialOut,
  output logic [IR_W-1:0] activeCode
);

  logic [IR_W-1:0] irShift;
  logic            irShiftGo;
  logic            irUpdateGo;

  assign irShiftGo  = selInstr & shiftEn;
  assign irUpdateGo = selInstr & updateEn & ~shiftEn & ~captureEn;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift    <= '0;
      activeCode <= CODE_FUNCTIONAL;
    end else begin
      if (irShiftGo) begin
        irShift <= {tdi, irShift[IR_W-1:1]};
      end
      if (irUpdateGo) begin
        activeCode <= irShift;
      end
    end
  end

  assign irSerialOut = irShift[0];

  always_comb begin
    stb.chainShift   = ~selInstr & shiftEn;
    stb.chainCapture = ~selInstr & captureEn & ~shiftEn;
    stb.chainUpdate  = ~selInstr & updateEn & ~shiftEn & ~captureEn;
    stb.extTest      = (activeCode == CODE_INTERCONN);
    stb.intTest      = (activeCode == CODE_CORETEST);
  end

endmodule

// File: rtl/collar_datapath.sv
module collar_datapath
  import collar_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 6
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  collarStrobes_t     stb,
  input  logic [NUM_IN-1:0]  hostIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] hostOut,
  output logic               chainSerialOut
);

  localparam int CHAIN_LEN = NUM_IN + NUM_OUT;

  logic [CHAIN_LEN:0] link;

  assign link[0]        = tdi;
  assign chainSerialOut = link[CHAIN_LEN];

  // input-side cells: observe host wiring, control the core
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inCell
    logic held;

    collar_cell u_cell (
      .tck        (tck),
      .trstN      (trstN),
      .serialIn   (link[i]),
      .parallelIn (hostIn[i]),
      .captureSel (stb.chainCapture & stb.extTest),
      .shiftSel   (stb.chainShift),
      .updateSel  (stb.chainUpdate),
      .serialOut  (link[i+1]),
      .heldVal    (held)
    );

    assign coreIn[i] = stb.intTest ? held : hostIn[i];
  end

  // output-side cells: observe the core, control host wiring
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outCell
    logic held;

    collar_cell u_cell (
      .tck        (tck),
      .trstN      (trstN),
      .serialIn   (link[NUM_IN+j]),
      .parallelIn (coreOut[j]),
      .captureSel (stb.chainCapture & stb.intTest),
      .shiftSel   (stb.chainShift),
      .updateSel  (stb.chainUpdate),
      .serialOut  (link[NUM_IN+j+1]),
      .heldVal    (held)
    );

    assign hostOut[j] = stb.extTest ? held : coreOut[j];
  end

endmodule

// File: rtl/core_collar.sv
module core_collar
  import collar_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 6
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  output logic               tdo,
  input  logic               selInstr,
  input  logic               shiftEn,
  input  logic               captureEn,
  input  logic               updateEn,
  input  logic [NUM_IN-1:0]  hostIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  output logic [NUM_OUT-1:0] hostOut
);

  collarStrobes_t  stb;
  logic            irSerialOut;
  logic            chainSerialOut;
  logic [IR_W-1:0] activeCode;

  collar_ctrl u_ctrl (
    .tck         (tck),
    .trstN       (trstN),
    .tdi         (tdi),
    .selInstr    (selInstr),
    .shiftEn     (shiftEn),
    .captureEn   (captureEn),
    .updateEn    (updateEn),
    .stb         (stb),
    .irSerialOut (irSerialOut),
    .activeCode  (activeCode)
  );

  collar_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .tck            (tck),
    .trstN          (trstN),
    .tdi            (tdi),
    .stb            (stb),
    .hostIn         (hostIn),
    .coreIn         (coreIn),
    .coreOut        (coreOut),
    .hostOut        (hostOut),
    .chainSerialOut (chainSerialOut)
  );

  assign tdo = selInstr ? irSerialOut : chainSerialOut;

endmodule

// File: rtl/core_collar_chk.sv
module core_collar_chk #(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 6
) (
  input logic               tck,
  input logic               trstN,
  input logic               updateEn,
  input logic [NUM_IN-1:0]  hostIn,
  input logic [NUM_IN-1:0]  coreIn,
  input logic [NUM_OUT-1:0] coreOut,
  input logic [NUM_OUT-1:0] hostOut,
  input logic [1:0]         activeCode
);

  // R2
  functional_in_chk: assert property (@(posedge tck) disable iff (!trstN)
    (activeCode == 2'b00 || activeCode == 2'b11) |-> (coreIn == hostIn));

  // R2
  functional_out_chk: assert property (@(posedge tck) disable iff (!trstN)
    (activeCode == 2'b00 || activeCode == 2'b11) |-> (hostOut == coreOut));

  // R11
  coretest_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (activeCode == 2'b10 && !updateEn) |=> $stable(coreIn));

  // R11
  interconn_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (activeCode == 2'b01 && !updateEn) |=> $stable(hostOut));

  // R3
  mode_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    !updateEn |=> $stable(activeCode));

endmodule

bind core_collar core_collar_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_OUT (NUM_OUT)
) u_chk (
  .tck        (tck),
  .trstN      (trstN),
  .updateEn   (updateEn),
  .hostIn     (hostIn),
  .coreIn     (coreIn),
  .coreOut    (coreOut),
  .hostOut    (hostOut),
  .activeCode (activeCode)
);

// File: tb/core_collar_tb.sv
module core_collar_tb;

  localparam int NI = 6;
  localparam int NO = 4;
  localparam int L  = NI + NO;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tdi = 1'b0;
  logic selInstr = 1'b0;
  logic shiftEn = 1'b0;
  logic captureEn = 1'b0;
  logic updateEn = 1'b0;
  logic [NI-1:0] hostIn = '0;
  logic [NO-1:0] coreOut = '0;
  logic [NI-1:0] coreIn;
  logic [NO-1:0] hostOut;
  logic tdo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [L-1:0] mSr = '0;
  logic [L-1:0] mUpd = '0;
  logic [1:0]   mCode = 2'b00;

  always #4 tck = ~tck;

  core_collar #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .tck(tck), .trstN(trstN), .tdi(tdi), .tdo(tdo),
    .selInstr(selInstr), .shiftEn(shiftEn), .captureEn(captureEn), .updateEn(updateEn),
    .hostIn(hostIn), .coreIn(coreIn), .coreOut(coreOut), .hostOut(hostOut)
  );

  function automatic logic [NI-1:0] expCoreIn();
    return (mCode == 2'b10) ? mUpd[NI-1:0] : hostIn;
  endfunction

  function automatic logic [NO-1:0] expHostOut();
    return (mCode == 2'b01) ? mUpd[L-1:NI] : coreOut;
  endfunction

  function automatic logic [L-1:0] capModel(logic [L-1:0] sr);
    logic [L-1:0] r = sr;
    if (mCode == 2'b01) r[NI-1:0] = hostIn;
    if (mCode == 2'b10) r[L-1:NI] = coreOut;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic checkPins(string tagIn, string tagOut);
    #1;
    chk(tagIn, 64'(coreIn), 64'(expCoreIn()));
    chk(tagOut, 64'(hostOut), 64'(expHostOut()));
  endtask

  task automatic loadInstr(logic [1:0] code, bit doUpdate);
    selInstr = 1'b1;
    shiftEn  = 1'b1;
    tdi = code[0];
    tick();
    tdi = code[1];
    tick();
    shiftEn = 1'b0;
    #1;
    chk("R4 mode register on tdo", 64'(tdo), 64'(code[0]));
    if (doUpdate) begin
      updateEn = 1'b1;
      tick();
      updateEn = 1'b0;
      mCode = code;
    end
    selInstr = 1'b0;
    #1;
  endtask

  task automatic shiftChain(logic [L-1:0] vin, output logic [L-1:0] vout);
    selInstr = 1'b0;
    shiftEn  = 1'b1;
    #1;
    for (int i = 0; i < L; i++) begin
      vout[L-1-i] = tdo;
      tdi = vin[L-1-i];
      tick();
      checkPins("R11 coreIn steady in shift", "R11 hostOut steady in shift");
    end
    shiftEn = 1'b0;
    mSr = vin;
  endtask

  task automatic captureChain();
    captureEn = 1'b1;
    tick();
    captureEn = 1'b0;
    mSr = capModel(mSr);
  endtask

  task automatic updateChain();
    updateEn = 1'b1;
    tick();
    updateEn = 1'b0;
    mUpd = mSr;
  endtask

  function automatic string capTag(logic [1:0] code);
    if (code == 2'b01) return "R6 R10 interconnect capture";
    if (code == 2'b10) return "R9 R10 core capture";
    return "R10 no capture in functional mode";
  endfunction

  task automatic roundTrip(logic [L-1:0] vA, logic [L-1:0] vB);
    logic [L-1:0] prev;
    logic [L-1:0] got;
    logic [L-1:0] expCap;
    prev = mSr;
    shiftChain(vA, got);
    chk("R5 chain order out", 64'(got), 64'(prev));
    captureChain();
    expCap = mSr;
    shiftChain(vB, got);
    chk(capTag(mCode), 64'(got), 64'(expCap));
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] junk;
    void'($urandom(32'd2718));

    hostIn  = 6'h2b;
    coreOut = 4'h9;
    repeat (3) tick();
    trstN = 1'b1;
    tick();

    // R1 reset state: functional and chain cleared
    #1;
    chk("R1 chain cleared on tdo", 64'(tdo), 64'd0);
    checkPins("R1 R2 functional coreIn after reset", "R1 R2 functional hostOut after reset");

    // R3 code shifted but not updated has no effect
    loadInstr(2'b01, 1'b0);
    checkPins("R3 no effect before update (coreIn)", "R3 no effect before update (hostOut)");

    // R1 hold registers zero: entering interconnect test drives zeros
    loadInstr(2'b01, 1'b1);
    #1;
    chk("R1 R7 hostOut from cleared hold regs", 64'(hostOut), 64'd0);

    // R8 core test from cleared hold regs
    loadInstr(2'b10, 1'b1);
    #1;
    chk("R1 R8 coreIn from cleared hold regs", 64'(coreIn), 64'd0);

    // R2 code 11 behaves as functional
    loadInstr(2'b11, 1'b1);
    hostIn  = 6'h15;
    coreOut = 4'h6;
    checkPins("R2 code 11 coreIn", "R2 code 11 hostOut");

    // R5 walking one through the chain, then R10 in functional mode
    roundTrip(10'b0000000001, 10'b1000000000);
    updateChain();
    checkPins("R2 update ignored in functional (coreIn)", "R2 update ignored in functional (hostOut)");

    // R7 R8 directed patterns
    loadInstr(2'b01, 1'b1);
    checkPins("R7 interconnect coreIn passes host", "R7 hostOut from hold regs");
    loadInstr(2'b10, 1'b1);
    hostIn = 6'h3f;
    checkPins("R8 coreIn from hold regs", "R8 hostOut passes core");

    for (int it = 0; it < 60; it++) begin
      logic [1:0] code;
      code = 2'($urandom % 4);
      loadInstr(code, 1'b1);
      hostIn  = NI'($urandom);
      coreOut = NO'($urandom);
      checkPins("R2 R8 coreIn per mode", "R2 R7 hostOut per mode");
      roundTrip(L'($urandom), L'($urandom));
      hostIn  = NI'($urandom);
      coreOut = NO'($urandom);
      checkPins("R11 coreIn before update", "R11 hostOut before update");
      updateChain();
      checkPins("R8 R11 coreIn after update", "R7 R11 hostOut after update");
    end

    shiftChain('0, junk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule